// File: doc/BRIEF.md
# ALU and Shifter Function Unit

A purely combinational function unit that sits between two operand buses and a result bus. One 5-bit select code picks the operation: an arithmetic operation from a single parallel adder, a bitwise logic operation, or a one-position shift of the B operand. A final two-way mux chooses between the ALU result and the shifter result. Four status flags come with every result: zero, negative, carry and signed overflow.

The select code is laid out as `fsel[4]` = unit select (0 ALU, 1 shifter), `fsel[3]` = ALU mode (0 arithmetic, 1 logic), `fsel[2:1]` = operation pair, `fsel[0]` = adder carry-in. For arithmetic, `fsel[2:1]` picks the adder's second operand: 00 zero, 01 B, 10 inverted B, 11 all ones. When the shifter is selected, `fsel[3:2]` picks pass, right shift or left shift, and a 0 enters the vacated bit.

The operand width and the adder build (bit-level ripple chain or a single vector addition) are parameters checked at elaboration.

Top module: `alu_shift_unit`

## Requirements
- R1: `fsel[4]`=0 routes the ALU result to `result`; `fsel[4]`=1 routes the shifter result to `result`.
- R2: With `fsel[4:3]`=00, `fsel[2:0]` gives: 000 A, 001 A+1, 010 A+B, 011 A+B+1, 100 A+~B, 101 A+~B+1 (A−B), 110 A−1, 111 A, all modulo 2^WIDTH.
- R3: For arithmetic codes, `flag_c` is the adder carry out of the MSB and `flag_v` is 1 exactly when the signed result of the operation does not fit in WIDTH bits.
- R4: With `fsel[4:3]`=01, `fsel[2:1]` gives: 00 A AND B, 01 A OR B, 10 A XOR B, 11 NOT A.
- R5: With `fsel[4]`=1, `fsel[3:2]` gives: 00 B, 01 B shifted right one place with 0 into the MSB, 10 B shifted left one place with 0 into the LSB, 11 B.
- R6: For every code, `flag_z` is 1 exactly when `result` is all zeros and `flag_n` equals `result[WIDTH-1]`.
- R7: For logic and shifter codes, `flag_c` and `flag_v` are 0.
- R8: For shifter codes, the A bus, `fsel[1]` and `fsel[0]` have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_bus | input | WIDTH | First operand |
| b_bus | input | WIDTH | Second operand, also the shifter input |
| fsel | input | 5 | Function select code |
| result | output | WIDTH | Selected result |
| flag_v | output | 1 | Signed overflow |
| flag_c | output | 1 | Adder carry out |
| flag_n | output | 1 | Result sign |
| flag_z | output | 1 | Result is zero |

## Verification
The bound checker tests on every evaluation that the zero and sign flags match the result, that carry and overflow stay low outside arithmetic, that the shifter codes produce the pass and shift patterns of B, and that A+B and AND give the right result with overflow following the operand and result signs. The full arithmetic table, the carry and overflow boundaries at the wrap points (0x7F+1, 0x80−1, 0xFF+1, 0−1), the unit-select mux and the insensitivity of the shifter to A and the low select bits are only shown by the bench's directed and swept scenarios against its own model.

// File: rtl/alu_fu_pkg.sv
package alu_fu_pkg;

   localparam int FSEL_W = 5;

   typedef enum int {
      ADD_RIPPLE,
      ADD_VECTOR
   } adder_kind_e;

   typedef enum logic [1:0] {
      SH_PASS  = 2'b00,
      SH_RIGHT = 2'b01,
      SH_LEFT  = 2'b10,
      SH_HOLD  = 2'b11
   } shift_op_e;

   typedef enum logic [1:0] {
      LG_AND = 2'b00,
      LG_OR  = 2'b01,
      LG_XOR = 2'b10,
      LG_NOT = 2'b11
   } logic_op_e;

   typedef enum logic [1:0] {
      OPB_ZERO = 2'b00,
      OPB_TRUE = 2'b01,
      OPB_INV  = 2'b10,
      OPB_ONES = 2'b11
   } opb_sel_e;

endpackage

// File: rtl/fu_arith.sv
module fu_arith
   import alu_fu_pkg::*;
#(
   parameter int          WIDTH      = 8,
   parameter adder_kind_e ADDER_KIND = ADD_RIPPLE
) (
   input  logic [WIDTH-1:0] opa,
   input  logic [WIDTH-1:0] opb,
   input  opb_sel_e         bsel,
   input  logic             cin,
   output logic [WIDTH-1:0] sum,
   output logic             cout,
   output logic             cmsb
);

   localparam int LOW_W = WIDTH - 1;

   logic [WIDTH-1:0] yop;

   always_comb begin
      unique case (bsel)
         OPB_ZERO: yop = '0;
         OPB_TRUE: yop = opb;
         OPB_INV:  yop = ~opb;
         default:  yop = '1;
      endcase
   end

   generate
      if (ADDER_KIND == ADD_RIPPLE) begin : g_ripple
         logic [WIDTH:0] cy;
         assign cy[0] = cin;
         for (genvar i = 0; i < WIDTH; i++) begin : g_cell
            assign sum[i]  = opa[i] ^ yop[i] ^ cy[i];
            assign cy[i+1] = (opa[i] & yop[i]) | (cy[i] & (opa[i] ^ yop[i]));
         end
         assign cout = cy[WIDTH];
         assign cmsb = cy[WIDTH-1];
      end else if (ADDER_KIND == ADD_VECTOR) begin : g_vector
         logic [LOW_W:0] low;
         assign low  = {1'b0, opa[LOW_W-1:0]} + {1'b0, yop[LOW_W-1:0]}
                       + {{LOW_W{1'b0}}, cin};
         assign cmsb = low[LOW_W];
         assign sum  = {opa[WIDTH-1] ^ yop[WIDTH-1] ^ low[LOW_W], low[LOW_W-1:0]};
         assign cout = (opa[WIDTH-1] & yop[WIDTH-1])
                     | (low[LOW_W] & (opa[WIDTH-1] ^ yop[WIDTH-1]));
      end else begin : g_bad_kind
         $error("fu_arith: unsupported ADDER_KIND");
      end
   endgenerate

endmodule

// File: rtl/fu_logic.sv
module fu_logic
   import alu_fu_pkg::*;
#(
   parameter int WIDTH = 8
) (
   input  logic [WIDTH-1:0] opa,
   input  logic [WIDTH-1:0] opb,
   input  logic_op_e        op,
   output logic [WIDTH-1:0] res
);

   always_comb begin
      unique case (op)
         LG_AND:  res = opa & opb;
         LG_OR:   res = opa | opb;
         LG_XOR:  res = opa ^ opb;
         default: res = ~opa;
      endcase
   end

endmodule

// File: rtl/fu_shift.sv
module fu_shift
   import alu_fu_pkg::*;
#(
   parameter int WIDTH = 8
) (
   input  logic [WIDTH-1:0] din,
   input  shift_op_e        op,
   input  logic             fill_r,
   input  logic             fill_l,
   output logic [WIDTH-1:0] dout
);

   generate
      for (genvar i = 0; i < WIDTH; i++) begin : g_bit
         logic from_hi;
         logic from_lo;
         if (i == WIDTH - 1) begin : g_top
            assign from_hi = fill_r;
         end else begin : g_mid_hi
            assign from_hi = din[i+1];
         end
         if (i == 0) begin : g_bot
            assign from_lo = fill_l;
         end else begin : g_mid_lo
            assign from_lo = din[i-1];
         end
         assign dout[i] = (op == SH_RIGHT) ? from_hi :
                          (op == SH_LEFT)  ? from_lo : din[i];
      end
   endgenerate

endmodule

// File: rtl/alu_shift_unit.sv
module alu_shift_unit
   import alu_fu_pkg::*;
#(
   parameter int          WIDTH      = 8,
   parameter adder_kind_e ADDER_KIND = ADD_RIPPLE
) (
   input  logic [WIDTH-1:0]  a_bus,
   input  logic [WIDTH-1:0]  b_bus,
   input  logic [FSEL_W-1:0] fsel,
   output logic [WIDTH-1:0]  result,
   output logic              flag_v,
   output logic              flag_c,
   output logic              flag_n,
   output logic              flag_z
);

   localparam int MSB = WIDTH - 1;

   generate
      if (WIDTH < 2) begin : g_bad_width
         $error("alu_shift_unit: WIDTH must be at least 2");
      end
   endgenerate

   logic             use_shift;
   logic             use_logic;
   logic [WIDTH-1:0] arith_res;
   logic [WIDTH-1:0] logic_res;
   logic [WIDTH-1:0] shift_res;
   logic [WIDTH-1:0] alu_res;
   logic             add_cout;
   logic             add_cmsb;

   assign use_shift = fsel[4];
   assign use_logic = fsel[3];

   fu_arith #(
      .WIDTH      (WIDTH),
      .ADDER_KIND (ADDER_KIND)
   ) i_arith (
      .opa  (a_bus),
      .opb  (b_bus),
      .bsel (opb_sel_e'(fsel[2:1])),
      .cin  (fsel[0]),
      .sum  (arith_res),
      .cout (add_cout),
      .cmsb (add_cmsb)
   );

   fu_logic #(
      .WIDTH (WIDTH)
   ) i_logic (
      .opa (a_bus),
      .opb (b_bus),
      .op  (logic_op_e'(fsel[2:1])),
      .res (logic_res)
   );

   fu_shift #(
      .WIDTH (WIDTH)
   ) i_shift (
      .din    (b_bus),
      .op     (shift_op_e'(fsel[3:2])),
      .fill_r (1'b0),
      .fill_l (1'b0),
      .dout   (shift_res)
   );

   assign alu_res = use_logic ? logic_res : arith_res;
   assign result  = use_shift ? shift_res : alu_res;

   assign flag_z = ~|result;
   assign flag_n = result[MSB];
   assign flag_c = ~use_shift & ~use_logic & add_cout;
   assign flag_v = ~use_shift & ~use_logic & (add_cout ^ add_cmsb);

endmodule

// File: rtl/alu_shift_unit_chk.sv
module alu_shift_unit_chk #(
   parameter int WIDTH = 8
) (
   input logic [WIDTH-1:0] a_bus,
   input logic [WIDTH-1:0] b_bus,
   input logic [4:0]       fsel,
   input logic [WIDTH-1:0] result,
   input logic             flag_v,
   input logic             flag_c,
   input logic             flag_n,
   input logic             flag_z
);

   always_comb begin
      // R6: zero and sign flags follow the result
      a_r6_zero_flag: assert (flag_z == (result == '0));
      a_r6_sign_flag: assert (flag_n == result[WIDTH-1]);
      // R7: carry and overflow quiet outside arithmetic
      if (fsel[4] || fsel[3]) begin
         a_r7_quiet_cv: assert (!flag_c && !flag_v);
      end
      // R5: shifter patterns
      if (fsel[4] && fsel[3:2] == 2'b01) begin
         a_r5_shift_right: assert (result == (b_bus >> 1));
      end
      if (fsel[4] && fsel[3:2] == 2'b10) begin
         a_r5_shift_left: assert (result == (b_bus << 1));
      end
      if (fsel[4] && fsel[3] == fsel[2]) begin
         a_r5_shift_pass: assert (result == b_bus);
      end
      // R4: logic AND
      if (fsel[4:1] == 4'b0100) begin
         a_r4_and: assert (result == (a_bus & b_bus));
      end
      // R2 / R3: plain addition and its overflow rule from signs
      if (fsel == 5'b00010) begin
         a_r2_add: assert (result == WIDTH'(a_bus + b_bus));
         a_r3_add_overflow: assert (flag_v == ((a_bus[WIDTH-1] == b_bus[WIDTH-1])
                                   && (result[WIDTH-1] != a_bus[WIDTH-1])));
      end
   end

endmodule

bind alu_shift_unit alu_shift_unit_chk #(.WIDTH(WIDTH)) i_chk (
   .a_bus  (a_bus),
   .b_bus  (b_bus),
   .fsel   (fsel),
   .result (result),
   .flag_v (flag_v),
   .flag_c (flag_c),
   .flag_n (flag_n),
   .flag_z (flag_z)
);

// File: tb/test_alu_shift_unit.sv
module test_alu_shift_unit;

   localparam int CLK_PERIOD = 10;
   localparam int W          = 8;
   localparam int MASK       = (1 << W) - 1;
   localparam int SMAX       = (1 << (W - 1)) - 1;
   localparam int SMIN       = -(1 << (W - 1));

   typedef struct {
      logic [W-1:0] f;
      logic         v;
      logic         c;
      logic         n;
      logic         z;
      logic         arith;
      string        tag;
   } exp_t;

   logic         clk = 1'b0;
   logic [W-1:0] a_bus = '0;
   logic [W-1:0] b_bus = '0;
   logic [4:0]   fsel = '0;
   logic [W-1:0] result;
   logic         flag_v, flag_c, flag_n, flag_z;

   int   checks = 0;
   int   fails  = 0;
   exp_t sb[$];

   always #(CLK_PERIOD / 2) clk = ~clk;

   alu_shift_unit #(.WIDTH(W)) i_alu_shift_unit (
      .a_bus  (a_bus),
      .b_bus  (b_bus),
      .fsel   (fsel),
      .result (result),
      .flag_v (flag_v),
      .flag_c (flag_c),
      .flag_n (flag_n),
      .flag_z (flag_z)
   );

   function automatic exp_t model(logic [4:0] fs, logic [W-1:0] a, logic [W-1:0] b, string tag);
      exp_t e;
      int   au = a;
      int   bu = b;
      int   as = $signed(a);
      int   bs = $signed(b);
      int   u  = 0;
      int   s  = 0;
      e.v = 1'b0;
      e.c = 1'b0;
      e.arith = 1'b0;
      if (fs[4]) begin
         case (fs[3:2])
            2'b01:   e.f = b >> 1;
            2'b10:   e.f = b << 1;
            default: e.f = b;
         endcase
      end else if (fs[3]) begin
         case (fs[2:1])
            2'b00:   e.f = a & b;
            2'b01:   e.f = a | b;
            2'b10:   e.f = a ^ b;
            default: e.f = ~a;
         endcase
      end else begin
         case (fs[2:0])
            3'b000: begin u = au;                s = as;          end
            3'b001: begin u = au + 1;            s = as + 1;      end
            3'b010: begin u = au + bu;           s = as + bs;     end
            3'b011: begin u = au + bu + 1;       s = as + bs + 1; end
            3'b100: begin u = au + (MASK - bu);  s = as - bs - 1; end
            3'b101: begin u = au + (MASK - bu) + 1; s = as - bs;  end
            3'b110: begin u = au + MASK;         s = as - 1;      end
            default: begin u = au + MASK + 1;    s = as;          end
         endcase
         e.f = u[W-1:0];
         e.c = (u >> W) != 0;
         e.v = (s > SMAX) || (s < SMIN);
         e.arith = 1'b1;
      end
      e.z = (e.f == '0);
      e.n = e.f[W-1];
      e.tag = tag;
      return e;
   endfunction

   // Driver: applies one vector and queues the expected outputs.
   task automatic drive(input logic [4:0] fs, input logic [W-1:0] a,
                        input logic [W-1:0] b, input string tag);
      @(posedge clk);
      fsel  = fs;
      a_bus = a;
      b_bus = b;
      sb.push_back(model(fs, a, b, tag));
   endtask

   task automatic cmp(input string what, input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s %s: actual %0h expected %0h (fsel=%b a=%0h b=%0h)",
                  tag, what, act, exp, fsel, a_bus, b_bus);
      end
   endtask

   // Monitor: compares outputs half a period after each applied vector.
   always @(negedge clk) begin
      if (sb.size() > 0) begin
         exp_t e;
         e = sb.pop_front();
         cmp("result", e.tag, int'(result), int'(e.f));
         cmp("carry",  e.arith ? "R3" : "R7", int'(flag_c), int'(e.c));
         cmp("ovf",    e.arith ? "R3" : "R7", int'(flag_v), int'(e.v));
         cmp("zero",   "R6", int'(flag_z), int'(e.z));
         cmp("sign",   "R6", int'(flag_n), int'(e.n));
      end
   end

   initial begin
      #(CLK_PERIOD * 200000);
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   function automatic string tag_of(logic [4:0] fs);
      if (fs[4])      return "R5";
      else if (fs[3]) return "R4";
      else            return "R2";
   endfunction

   initial begin
      logic [31:0] seed;
      logic [W-1:0] pat_a[8];
      logic [W-1:0] pat_b[8];
      pat_a = '{8'h00, 8'h7F, 8'h80, 8'hFF, 8'h01, 8'hA5, 8'h3C, 8'h80};
      pat_b = '{8'h00, 8'h01, 8'h01, 8'h01, 8'hFF, 8'h5A, 8'hC3, 8'h80};

      // reset-like idle state: all-zero inputs (R6)
      drive(5'b00000, 8'h00, 8'h00, "R6");

      // R2/R3 corner cases at the wrap points
      drive(5'b00001, 8'h7F, 8'h00, "R3");  // 0x7F+1: V=1, C=0
      drive(5'b00110, 8'h80, 8'h00, "R3");  // 0x80-1: V=1, C=1
      drive(5'b00001, 8'hFF, 8'h00, "R3");  // 0xFF+1: C=1, Z=1
      drive(5'b00110, 8'h00, 8'h00, "R3");  // 0-1: C=0
      drive(5'b00101, 8'h00, 8'h80, "R3");  // 0-(-128): V=1
      drive(5'b00101, 8'h05, 8'h05, "R2");  // A-B = 0
      drive(5'b00111, 8'h5C, 8'h00, "R2");  // code 111 gives A

      // R1: same operands, unit select flips
      drive(5'b00010, 8'h21, 8'h84, "R1");
      drive(5'b10000, 8'h21, 8'h84, "R1");

      // R5 boundaries: bits leaving the ends, zero fill
      drive(5'b10100, 8'h00, 8'h01, "R5");
      drive(5'b11000, 8'h00, 8'h80, "R5");
      drive(5'b11100, 8'h00, 8'hC3, "R5");

      // R8: shifter ignores A, fsel[1], fsel[0]
      for (int k = 0; k < 4; k++) begin
         drive({3'b101, k[1:0]}, 8'hFF, 8'h96, "R8");
         drive({3'b110, k[1:0]}, 8'h5A, 8'h96, "R8");
         drive({3'b100, k[1:0]}, 8'h33, 8'h96, "R8");
      end

      // sweep of all select codes over operand patterns
      for (int fs = 0; fs < 32; fs++) begin
         for (int p = 0; p < 8; p++) begin
            drive(fs[4:0], pat_a[p], pat_b[p], tag_of(fs[4:0]));
         end
      end

      // pseudo-random vectors
      seed = 32'h1234_5678;
      for (int i = 0; i < 300; i++) begin
         seed = seed ^ (seed << 13);
         seed = seed ^ (seed >> 17);
         seed = seed ^ (seed << 5);
         drive(seed[4:0], seed[15:8], seed[27:20], tag_of(seed[4:0]));
      end

      @(posedge clk);
      @(posedge clk);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule